// File: doc/BRIEF.md
# Multi-Input Wake-Up Controller

The controller watches a set of asynchronous wake-up inputs, grouped into banks of channels. Every input first passes through a two-flop synchroniser. Each channel then looks for an edge in the direction its polarity bit selects. When an enabled channel sees that edge, it sets a sticky pending flag.

The enabled pending flags of all banks combine into one wake-up request for the power controller. Each channel can also be armed for interrupts on its own, independently of the wake-up enable. An armed pending channel drives the one of four interrupt lines that its 2-bit routing code picks.

Software programs the unit over a word-wide register bus that is written synchronously and read combinationally. A pending flag is never cleared by writing the pending register. It is cleared only by writing a one to the matching bit of a separate, write-only clear register.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset, every readable register of both banks reads 0, `wake_req` is 0 and `irq_req` is 0.
- R2: The address is {bank, index}, with the bank in bit 3 and the index in bits 2:0. The indices are: 0 wake enable, 1 interrupt enable, 2 edge polarity, 3 pending (read-only), 4 pending clear (write-only, read value undefined), 5 routing low, 6 routing high. Indices 0, 1, 2, 5 and 6 read back the last value written. A write to index 3 leaves the pending flags unchanged.
- R3: Input `wake_in[16*b+c]` is channel c of bank b. With its polarity bit at 0, a 0-to-1 transition sets the pending bit and a 1-to-0 transition does not. With its polarity bit at 1, the reverse holds.
- R4: A channel whose wake-enable bit is 0 never sets its pending bit. Enabling it later does not recover an edge that was seen while it was disabled.
- R5: Writing the clear register clears each pending bit whose mask bit is 1 and leaves every pending bit whose mask bit is 0 unchanged.
- R6: If an edge is detected on a channel in the same cycle as a clear write to that channel, the pending bit stays set.
- R7: `wake_req` is 1 exactly when some channel in either bank is both pending and wake-enabled. Clearing a channel's enable removes it from `wake_req` without clearing its pending bit.
- R8: Channel n takes its routing code from bits 2n+1:2n of {routing high, routing low}. `irq_req[k]` is 1 exactly when some channel is pending, interrupt-enabled and has routing code k.
- R9: A pending channel whose interrupt-enable bit is 0 drives no `irq_req` line, but it still contributes to `wake_req` when it is wake-enabled.
- R10: The two banks are independent. Registers, edges and clears in one bank do not change the pending flags of the other bank, and lines routed from both banks OR together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_in | input | 32 | Asynchronous wake-up inputs, bank-major order |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address {bank, index} |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Combinational register read data |
| wake_req | output | 1 | Wake-up request |
| irq_req | output | 4 | Interrupt request lines |

## Verification
The assertions check four rules on every cycle:
- a disabled channel never gains a pending bit;
- a clear write removes every masked bit that has no edge in that cycle;
- a detected edge on an enabled channel always leaves its bit set, even against a clear write;
- a write to the pending index changes nothing when no edge is present.

Only the bench's scenarios can show the following, because each one depends on how the bus and the inputs are driven over several cycles:
- the edge polarity, including the synchroniser latency, swept over all 32 channels;
- the mapping of each channel to its routing code, swept over every channel and all four codes;
- the gating of interrupts apart from wake-ups;
- the independence of the two banks.

// File: rtl/wkup_pkg.sv
// Package wkup_pkg: shared register-index encoding and defaults for the
// multi-input wake-up controller. Assumes an index field of three bits.
package wkup_pkg;
    localparam int DEF_BANKS = 2;
    localparam int DEF_CH    = 16;
    localparam int DEF_NIRQ  = 4;
    localparam int IDX_W     = 3;

    typedef enum logic [IDX_W-1:0] {
        RG_ENABLE   = 3'd0,
        RG_IEN      = 3'd1,
        RG_EDGE     = 3'd2,
        RG_PEND     = 3'd3,
        RG_CLEAR    = 3'd4,
        RG_ROUTE_LO = 3'd5,
        RG_ROUTE_HI = 3'd6,
        RG_SPARE    = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/wkup_sync.sv
// Module wkup_sync: two-flop synchroniser plus polarity-selected edge detect
// for one bank. Assumes inputs are asynchronous level signals; hit is a
// one-cycle pulse per detected edge, valid for the cycle after the change
// reaches the second flop.
module wkup_sync #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pin,
    input  logic [CH-1:0] falling_sel,
    output logic [CH-1:0] hit
);
    logic [CH-1:0] meta_q, stab_q, prev_q;

    // Resynchronise the pins and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    // Pick the rising or falling transition per channel.
    always_comb begin
        hit = (~falling_sel & stab_q & ~prev_q) | (falling_sel & prev_q & ~stab_q);
    end
endmodule

// File: rtl/wkup_bank.sv
// Module wkup_bank: register file, pending latch and interrupt routing for
// one bank. Assumes NIRQ <= 4 so that each routing code fits in the two
// routing words, and that hit comes from a registered edge detector.
module wkup_bank
    import wkup_pkg::*;
#(
    parameter int CH   = 16,
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            we,
    input  logic [IDX_W-1:0] idx,
    input  logic [CH-1:0]   wdata,
    input  logic [CH-1:0]   hit,
    output logic [CH-1:0]   rdata,
    output logic [CH-1:0]   falling_sel,
    output logic            wake_o,
    output logic [NIRQ-1:0] irq_o
);
    localparam int CW = $clog2(NIRQ);

    logic [CH-1:0]   en_q, ien_q, edge_q, pend_q, rlo_q, rhi_q;
    logic [CH-1:0]   clr_mask, armed, fresh;
    logic [2*CH-1:0] route_all;
    logic            wr_hit;

    assign wr_hit      = sel & we;
    assign clr_mask    = (wr_hit && idx == RG_CLEAR) ? wdata : '0;
    assign fresh       = hit & en_q;
    assign falling_sel = edge_q;
    assign armed       = pend_q & ien_q;
    assign route_all   = {rhi_q, rlo_q};

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ien_q  <= '0;
            edge_q <= '0;
            rlo_q  <= '0;
            rhi_q  <= '0;
        end else if (wr_hit) begin
            case (idx)
                RG_ENABLE:   en_q   <= wdata;
                RG_IEN:      ien_q  <= wdata;
                RG_EDGE:     edge_q <= wdata;
                RG_ROUTE_LO: rlo_q  <= wdata;
                RG_ROUTE_HI: rhi_q  <= wdata;
                default:     ;
            endcase
        end
    end

    // Pending latch: clear by mask, a same-cycle new edge takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | fresh;
    end

    // Register read multiplexer; clear and spare indices return zero.
    always_comb begin
        case (idx)
            RG_ENABLE:   rdata = en_q;
            RG_IEN:      rdata = ien_q;
            RG_EDGE:     rdata = edge_q;
            RG_PEND:     rdata = pend_q;
            RG_ROUTE_LO: rdata = rlo_q;
            RG_ROUTE_HI: rdata = rhi_q;
            default:     rdata = '0;
        endcase
    end

    // Bank wake contribution from enabled pending channels.
    assign wake_o = |(pend_q & en_q);

    // Steer each armed channel onto the line its routing code names.
    always_comb begin
        irq_o = '0;
        for (int n = 0; n < CH; n++) begin
            if (armed[n]) irq_o[route_all[n*CW +: CW]] = 1'b1;
        end
    end

    // R4: a channel disabled in the previous cycle gains no pending bit.
    p_disabled_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R5: masked bits without a concurrent edge are gone after the write.
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pend_q & $past(clr_mask & ~fresh)) == '0));

    // R6: an edge on an enabled channel always leaves its bit set.
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh != '0) |=> ((pend_q & $past(fresh)) == $past(fresh)));

    // R2: writing the pending index does not alter pending state.
    p_pend_readonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == RG_PEND && fresh == '0) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/wkup_ctrl.sv
// Module wkup_ctrl: top of the multi-input wake-up controller. One
// synchroniser and one register bank per bank of channels; address bits
// above the index pick the bank. Assumes BANKS is a power of two >= 2.
module wkup_ctrl
    import wkup_pkg::*;
#(
    parameter int BANKS = DEF_BANKS,
    parameter int CH    = DEF_CH,
    parameter int NIRQ  = DEF_NIRQ,
    localparam int BW   = $clog2(BANKS),
    localparam int AW   = IDX_W + BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANKS*CH-1:0] wake_in,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [CH-1:0]       bus_wdata,
    output logic [CH-1:0]       bus_rdata,
    output logic                wake_req,
    output logic [NIRQ-1:0]     irq_req
);
    logic [CH-1:0]   bank_rd   [BANKS];
    logic [NIRQ-1:0] bank_irq  [BANKS];
    logic [BANKS-1:0] bank_wake;
    logic [BW-1:0]   bank_sel;

    assign bank_sel = bus_addr[AW-1:IDX_W];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CH-1:0] hit, falling_sel;

        wkup_sync #(.CH(CH)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (wake_in[b*CH +: CH]),
            .falling_sel(falling_sel),
            .hit        (hit)
        );

        wkup_bank #(.CH(CH), .NIRQ(NIRQ)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (bank_sel == BW'(b)),
            .we         (bus_we),
            .idx        (bus_addr[IDX_W-1:0]),
            .wdata      (bus_wdata),
            .hit        (hit),
            .rdata      (bank_rd[b]),
            .falling_sel(falling_sel),
            .wake_o     (bank_wake[b]),
            .irq_o      (bank_irq[b])
        );
    end

    // Return the read data of the addressed bank.
    assign bus_rdata = bank_rd[bank_sel];

    // Merge the per-bank requests onto the shared outputs.
    always_comb begin
        irq_req = '0;
        for (int b = 0; b < BANKS; b++) irq_req = irq_req | bank_irq[b];
    end
    assign wake_req = |bank_wake;
endmodule

// File: tb/wkup_ctrl_bench.sv
module wkup_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wake_req;
    logic [3:0]  irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] en_s [2], ien_s [2], edg_s [2];

    always #2 clk = ~clk;

    wkup_ctrl u_wkup_ctrl (
        .clk(clk), .rst_n(rst_n), .wake_in(win), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_req(wake_req), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int b, input int idx, input logic [15:0] v);
        @(negedge clk);
        bus_addr = 4'(b*8 + idx); bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (idx == 0) en_s[b] = v;
        if (idx == 1) ien_s[b] = v;
        if (idx == 2) edg_s[b] = v;
    endtask

    task automatic rd(input int b, input int idx, output logic [15:0] v);
        @(negedge clk);
        bus_addr = 4'(b*8 + idx);
        #1 v = bus_rdata;
    endtask

    task automatic tog(input int ch);
        @(negedge clk);
        win[ch] = ~win[ch];
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic set_edge(input int b, input int c, input bit fall);
        logic [15:0] m;
        m = 16'(1) << c;
        wr(b, 2, fall ? (edg_s[b] | m) : (edg_s[b] & ~m));
    endtask

    task automatic route(input int b, input int c, input int code);
        if (c < 8) begin
            wr(b, 5, 16'(code) << (2*c)); wr(b, 6, 16'h0);
        end else begin
            wr(b, 5, 16'h0); wr(b, 6, 16'(code) << (2*(c-8)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int b = 0; b < 2; b++) begin en_s[b] = 0; ien_s[b] = 0; edg_s[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every readable register and the outputs
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 7; i++)
                if (i != 4) begin rd(b, i, v); check("R1 reg", v, 0); end
        check("R1 wake", wake_req, 0);
        check("R1 irq", irq_req, 0);

        // R2: readback of the configuration registers in both banks
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 7; i++) begin
                if (i == 3 || i == 4) continue;
                wr(b, i, 16'hA5C3 ^ 16'(i*16'h1111) ^ 16'(b*16'h0F0F));
            end
            for (int i = 0; i < 7; i++) begin
                if (i == 3 || i == 4) continue;
                rd(b, i, v);
                check("R2 readback", v, 16'hA5C3 ^ 16'(i*16'h1111) ^ 16'(b*16'h0F0F));
            end
            for (int i = 0; i < 7; i++) if (i != 3 && i != 4) wr(b, i, 16'h0);
        end

        // R3 R4 R10: polarity and enable sweep over every channel
        for (int ch = 0; ch < 32; ch++) begin
            int b, c;
            b = ch / 16; c = ch % 16;
            wr(b, 0, 16'(1) << c);
            tog(ch);
            rd(b, 3, v); check("R3 rise pol0 sets", v, 16'(1) << c);
            rd(1-b, 3, v); check("R10 other bank untouched", v, 0);
            check("R7 wake from pending", wake_req, 1);
            wr(b, 4, 16'hFFFF);
            tog(ch);
            rd(b, 3, v); check("R3 fall pol0 ignored", v, 0);
            set_edge(b, c, 1'b1);
            tog(ch);
            rd(b, 3, v); check("R3 rise pol1 ignored", v, 0);
            tog(ch);
            rd(b, 3, v); check("R3 fall pol1 sets", v, 16'(1) << c);
            wr(b, 4, 16'hFFFF);
            set_edge(b, c, 1'b0);
            wr(b, 0, 16'h0);
            tog(ch);
            rd(b, 3, v); check("R4 disabled no set", v, 0);
            wr(b, 0, 16'(1) << c);
            @(negedge clk); #1;
            rd(b, 3, v); check("R4 no stale after enable", v, 0);
            check("R4 wake low", wake_req, 0);
            tog(ch);
            wr(b, 0, 16'h0);
        end

        // R8 R9: routing sweep over every channel and code
        for (int ch = 0; ch < 32; ch++) begin
            int b, c;
            b = ch / 16; c = ch % 16;
            wr(b, 0, 16'(1) << c);
            wr(b, 1, 16'(1) << c);
            for (int k = 0; k < 4; k++) begin
                route(b, c, k);
                tog(ch);
                check("R8 irq line", irq_req, 32'(1) << k);
                wr(b, 4, 16'(1) << c);
                @(negedge clk); #1;
                check("R8 irq cleared", irq_req, 0);
                tog(ch);
            end
            wr(b, 1, 16'h0);
            tog(ch);
            check("R9 no irq without ien", irq_req, 0);
            check("R9 wake still set", wake_req, 1);
            wr(b, 4, 16'hFFFF);
            tog(ch);
            wr(b, 0, 16'h0);
            route(b, c, 0);
        end

        // R5 R2: partial clear, zero mask, pending index write
        wr(0, 0, 16'h0007);
        tog(0); tog(1); tog(2);
        rd(0, 3, v); check("R5 three pending", v, 16'h0007);
        wr(0, 4, 16'h0002);
        rd(0, 3, v); check("R5 partial clear", v, 16'h0005);
        wr(0, 4, 16'h0000);
        rd(0, 3, v); check("R5 zero mask keeps", v, 16'h0005);
        wr(0, 3, 16'h0000);
        rd(0, 3, v); check("R2 pending write ignored", v, 16'h0005);
        wr(0, 4, 16'hFFFF);
        wr(0, 3, 16'hFFFF);
        rd(0, 3, v); check("R2 pending write no set", v, 0);
        tog(0); tog(1); tog(2);

        // R6: edge and clear in the same cycle
        wr(0, 0, 16'h0020);
        @(negedge clk); win[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 16'h0020; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(0, 3, v); check("R6 edge wins over clear", v, 16'h0020);
        wr(0, 4, 16'h0020);
        rd(0, 3, v); check("R6 later clear works", v, 0);
        tog(5);

        // R7: disable removes wake without clearing pending, bank 1 too
        wr(1, 0, 16'h8000);
        tog(31);
        check("R7 wake bank1", wake_req, 1);
        wr(1, 0, 16'h0);
        #1 check("R7 wake off when disabled", wake_req, 0);
        rd(1, 3, v); check("R7 pending kept", v, 16'h8000);
        wr(1, 0, 16'h8000);
        #1 check("R7 wake back", wake_req, 1);
        wr(1, 4, 16'hFFFF);
        tog(31);

        // R10: lines from both banks OR together
        wr(0, 0, 16'h0001); wr(0, 1, 16'h0001); wr(0, 5, 16'h0002);
        wr(1, 0, 16'h0002); wr(1, 1, 16'h0002); wr(1, 5, 16'h000C);
        tog(0); tog(17);
        check("R10 or of banks", irq_req, 4'b1100);
        wr(1, 4, 16'hFFFF);
        #1 check("R10 bank1 clear only", irq_req, 4'b0100);
        rd(0, 3, v); check("R10 bank0 kept", v, 16'h0001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule